// File: doc/BRIEF.md
# Receive Frame Position Counter with Programmable Offset

This block tracks the bit position inside a 256-bit receive frame clocked at 2.048 MHz. It holds a 9-bit position counter in half-bit units that steps by two on every receive clock edge, so one full turn of the counter (modulo 512) is one frame. A single 9-bit offset word serves one of two roles. A mode bit selects which role applies.

With the mode bit low, the shared sync pin is an input. Whenever it is sampled high on a clock edge, the counter is loaded with the offset word, so an external frame pulse aligns the internal count. With the mode bit high, the pin becomes an output. The block drives a one-clock frame marker on it in the cycle where the counter equals the offset word. This places the marker at any chosen bit of the frame. To mark bit position BP, program the offset as (2 + 2*BP) mod 512.

Top module: `rx_frame_pos_counter`

## Requirements
- R1: A synchronous reset forces the counter output to 0 and holds the marker output and the pin drive enable low.
- R2: When no load happens at an edge, the counter value after the edge equals the value before it plus 2, modulo 512.
- R3: With the mode bit at 0, a sync input sampled at 1 on an edge makes the counter equal the offset word after that edge.
- R4: A sync input held at 1 over several edges in mode 0 reloads the offset on each of those edges, so the counter stays at the offset.
- R5: With the mode bit at 1, the sync input has no effect: the counter keeps advancing by 2.
- R6: The pin drive enable is high in the cycle after an edge that sampled the mode bit at 1, and low after one that sampled it at 0.
- R7: In mode 1, the marker is high in exactly those cycles where the counter equals the offset word. With the offset set to (2 + 2*BP) mod 512, it is high for exactly one cycle in any 256 consecutive cycles.
- R8: In mode 0, the marker stays low.
- R9: A new offset word applies from the next edge. It is used at the next load in mode 0 and at the next compare in mode 1, with no marker pulse for the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| offset_i | input | 9 | Preload value (mode 0) or marker compare point (mode 1) |
| marker_mode_i | input | 1 | 0: sync loads the counter, 1: block drives the frame marker |
| sync_i | input | 1 | Frame sync input from the shared pin, used in mode 0 |
| marker_o | output | 1 | Frame marker to the shared pin, one clock wide |
| marker_oe_o | output | 1 | Drive enable for the shared pin |
| count_o | output | 9 | Current frame position in half-bit units |

## Verification
Every result is registered once, so each output reflects the inputs sampled at the preceding rising edge. A load shows on count_o one cycle after the sync edge. A marker is high in the same cycle the counter shows the matching value. The drive enable follows the mode bit one cycle later. The bench drives inputs on the falling edge and updates a reference model at the rising edge from the same sampled inputs. It then compares all three outputs on the next falling edge, so each check lands one cycle after its stimulus. It sweeps all 512 preload values and all 256 marker positions, and counts marker pulses over full-frame windows.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
    localparam int unsigned POS_W      = 9;
    localparam int unsigned POS_STEP   = 2;
    localparam int unsigned FRAME_BITS = (1 << POS_W) / POS_STEP;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pos_t cnt;
    } cnt_state_t;

    typedef struct packed {
        logic mark;
        logic oe;
    } mark_state_t;
endpackage

// File: rtl/rfo_counter.sv
module rfo_counter
    import rfo_pkg::*;
#(
    parameter int unsigned W    = POS_W,
    parameter int unsigned STEP = POS_STEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q_o,
    output logic [W-1:0] cnt_d_o
);
    localparam logic [W-1:0] INC = W'(STEP);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + INC;
        if (load_en) begin
            cnt_d = load_val;
        end
        if (rst) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt_q_o = cnt_q;
    assign cnt_d_o = cnt_d;
endmodule

// File: rtl/rfo_marker.sv
module rfo_marker
    import rfo_pkg::*;
#(
    parameter int unsigned W = POS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] offset,
    output logic         mark_o,
    output logic         oe_o
);
    mark_state_t st_d, st_q;

    always_comb begin
        st_d.oe   = mode;
        st_d.mark = mode && (cnt_next == offset);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mark_o = st_q.mark;
    assign oe_o   = st_q.oe;
endmodule

// File: rtl/rx_frame_pos_counter.sv
module rx_frame_pos_counter
    import rfo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] offset_i,
    input  logic             marker_mode_i,
    input  logic             sync_i,
    output logic             marker_o,
    output logic             marker_oe_o,
    output logic [POS_W-1:0] count_o
);
    logic             load_en;
    logic [POS_W-1:0] cnt_next;

    // A sync pulse only loads while the shared pin is an input.
    assign load_en = !marker_mode_i && sync_i;

    rfo_counter #(.W(POS_W), .STEP(POS_STEP)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (offset_i),
        .cnt_q_o  (count_o),
        .cnt_d_o  (cnt_next)
    );

    rfo_marker #(.W(POS_W)) u_mark (
        .clk      (clk),
        .rst      (rst),
        .mode     (marker_mode_i),
        .cnt_next (cnt_next),
        .offset   (offset_i),
        .mark_o   (marker_o),
        .oe_o     (marker_oe_o)
    );
endmodule

// File: rtl/rfo_checker.sv
module rfo_checker
    import rfo_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [POS_W-1:0] offset_i,
    input logic             marker_mode_i,
    input logic             sync_i,
    input logic             marker_o,
    input logic             marker_oe_o,
    input logic [POS_W-1:0] count_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !marker_o && !marker_oe_o)); // R1

    AST_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
        (marker_mode_i || !sync_i) |=> count_o == $past(count_o) + POS_W'(POS_STEP)); // R2

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!marker_mode_i && sync_i) |=> count_o == $past(offset_i)); // R3

    AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> marker_oe_o == $past(marker_mode_i)); // R6

    AST_MARK_AT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        marker_o |-> count_o == $past(offset_i)); // R7

    AST_NO_MARK_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        !marker_oe_o |-> !marker_o); // R8
endmodule

bind rx_frame_pos_counter rfo_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .offset_i      (offset_i),
    .marker_mode_i (marker_mode_i),
    .sync_i        (sync_i),
    .marker_o      (marker_o),
    .marker_oe_o   (marker_oe_o),
    .count_o       (count_o)
);

// File: tb/sim_rx_frame_pos_counter.sv
`timescale 1ns/1ps
module sim_rx_frame_pos_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] offset_i = '0;
    logic       marker_mode_i = 1'b0;
    logic       sync_i = 1'b0;
    logic       marker_o, marker_oe_o;
    logic [8:0] count_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [8:0] m_cnt  = '0;
    logic       m_mark = 1'b0;
    logic       m_oe   = 1'b0;

    always #2 clk = ~clk;

    rx_frame_pos_counter u0 (
        .clk           (clk),
        .rst           (rst),
        .offset_i      (offset_i),
        .marker_mode_i (marker_mode_i),
        .sync_i        (sync_i),
        .marker_o      (marker_o),
        .marker_oe_o   (marker_oe_o),
        .count_o       (count_o)
    );

    // Reference model built from the requirements.
    always @(posedge clk) begin
        logic [8:0] n;
        if (rst) begin
            n = '0;
        end else if (!marker_mode_i && sync_i) begin
            n = offset_i;
        end else begin
            n = m_cnt + 9'd2;
        end
        m_cnt  <= n;
        m_oe   <= !rst && marker_mode_i;
        m_mark <= !rst && marker_mode_i && (n == offset_i);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: inputs already set on the falling edge, compare on the next.
    task automatic step(input string tag);
        @(negedge clk);
        chk(tag, count_o, m_cnt, "count");
        chk(tag, marker_o, m_mark, "marker");
        chk(tag, marker_oe_o, m_oe, "oe");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        @(negedge clk);
        step("R1");
        step("R1");
        chk("R1", count_o, 0, "reset count");
        chk("R1", marker_o, 0, "reset marker");
        chk("R1", marker_oe_o, 0, "reset oe");
        rst = 1'b0;

        // R2: free run across a wrap.
        for (int i = 0; i < 300; i++) step("R2");

        // R3: every preload value, one sync pulse each; R8: no marker.
        for (int v = 0; v < 512; v++) begin
            offset_i = 9'(v);
            sync_i = 1'b1;
            step("R3");
            chk("R3", count_o, v, "loaded");
            sync_i = 1'b0;
            step("R8");
            chk("R8", marker_o, 0, "mode0 marker");
            step("R2");
        end

        // R4: held sync keeps reloading.
        offset_i = 9'd77;
        sync_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step("R4");
            chk("R4", count_o, 77, "held load");
        end
        // R9: offset change while held applies at next edge.
        offset_i = 9'd200;
        step("R9");
        chk("R9", count_o, 200, "new preload");
        sync_i = 1'b0;
        step("R2");

        // R6: switch to marker mode.
        marker_mode_i = 1'b1;
        step("R6");
        chk("R6", marker_oe_o, 1, "oe high");

        // R5: sync ignored in marker mode.
        sync_i = 1'b1;
        offset_i = 9'd3;
        for (int i = 0; i < 10; i++) step("R5");
        sync_i = 1'b0;

        // R7/R9: every marker position, one pulse per 256 cycles.
        for (int bp = 0; bp < 256; bp++) begin
            offset_i = 9'((2 + 2 * bp) % 512);
            step("R9");
            pulses = 0;
            for (int i = 0; i < 256; i++) begin
                step("R7");
                if (marker_o) begin
                    pulses++;
                    chk("R7", count_o, offset_i, "marker position");
                end
            end
            chk("R7", pulses, 1, "pulses per frame");
        end

        // R6: back to load mode drops the drive enable.
        marker_mode_i = 1'b0;
        step("R6");
        chk("R6", marker_oe_o, 0, "oe low");
        for (int i = 0; i < 20; i++) step("R8");

        // R1: reset mid-run.
        rst = 1'b1;
        step("R1");
        chk("R1", count_o, 0, "reset again");
        rst = 1'b0;
        step("R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule